// File: doc/BRIEF.md
# Multiplexed Expansion Bus Master Sequencer

This block turns one already-decoded host access into a complete cycle on a 32-bit multiplexed address/data peripheral bus. A request carries an 18-bit word address, four active-low byte-lane selects, a read/write flag, write data and a strobe style. The block latches the request and raises a bus request. It waits for the grant, then answers with an active-low grant acknowledge. It drives one address phase and a data phase of `DATA_CYCLES` clocks. It ends with a closing clock that pulses `done` and presents the read data.

Two strobe styles exist. The split style uses separate active-low write and read strobes. The level style uses a read/write level line, held high for reads and low for writes, together with a data strobe that goes low for both directions. While the block does not own the bus, every bus output is reported as released through `ctl_oe` and `ead_oe`. The data lines are also released while a read is in its data phase. A free-running bus clock output is the host clock inverted.

Top module: `xbus_master`

## Requirements
- R1: During reset and after it, before any request: `busy`, `done`, `hold`, `ctl_oe` and `ead_oe` are 0; `bgack_n`, `ale_n`, `wr_n` and `rd_n` are 1; `be_n` is 4'hF.
- R2: One clock after a request is accepted, `hold` goes high. While `grant` is low, `ctl_oe` stays 0 and `bgack_n` stays 1. The clock after `grant` is seen high, `bgack_n` goes low and `ctl_oe` goes high. Both stay that way until the access ends, and then `hold` and `bgack_n` are released together.
- R3: The address phase is the clock after the acknowledge clock. In it, `ead_out` equals `{14'b0, req_addr}` and `ead_oe` is 1.
- R4: `ale_n` goes low in the address phase. It stays low through the data phase and the closing clock.
- R5: `be_n` carries the request's active-low lane selects only during data-phase clocks. Bit 0 selects bits [7:0] and bit 3 selects bits [31:24]. In all other clocks `be_n` is 4'hF.
- R6: In the data phase of a write, `ead_out` equals the request write data unchanged and `ead_oe` is 1. In read data phases and in the closing clock, `ead_oe` is 0.
- R7: Split style (`strobe_mode`=0), write: `wr_n` is low exactly in the data-phase clocks, and `rd_n` stays high for the whole access.
- R8: Split style, read: `rd_n` is low exactly in the data-phase clocks, and `wr_n` stays high for the whole access.
- R9: Level style (`strobe_mode`=1): `wr_n` is the read/write line. From the address phase through the closing clock it is 1 for a read and 0 for a write, and it is 1 otherwise. `rd_n` is the data strobe and is low exactly in the data-phase clocks, for both directions.
- R10: The data phase lasts `DATA_CYCLES` clocks. A read captures `ead_in` on the edge that ends the last data-phase clock. `done` is high for exactly one clock (the closing clock), and during that clock `rd_data` holds the captured word.
- R11: `busy` is high from the clock after acceptance through the closing clock. A `req_valid` that arrives while `busy` is high is not accepted, and its fields have no effect on the running access.
- R12: `bus_clk` is the inverse of `clk`.
- R13: `strobe_mode` and all request fields are captured at acceptance. Changing them later does not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_mode | input | 1 | 0 split strobes, 1 level line plus data strobe |
| req_valid | input | 1 | Request present; accepted when idle |
| req_addr | input | 18 | Host word address (host byte address bits 19:2) |
| req_be_n | input | 4 | Active-low lane selects from the host data phase |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Captured read word |
| hold | output | 1 | Bus request to the arbiter |
| grant | input | 1 | Bus grant from the arbiter (tie high if sole master) |
| bgack_n | output | 1 | Active-low grant acknowledge |
| bus_clk | output | 1 | Inverted host clock |
| ctl_oe | output | 1 | Enable for strobe, latch and lane-select drivers |
| ale_n | output | 1 | Active-low address latch enable |
| wr_n | output | 1 | Write strobe (split) or read/write level (level) |
| rd_n | output | 1 | Read strobe (split) or data strobe (level) |
| be_n | output | 4 | Active-low byte-lane chip selects |
| ead_oe | output | 1 | Enable for the multiplexed data lines |
| ead_out | output | 32 | Multiplexed address/data out |
| ead_in | input | 32 | Multiplexed data in |

## Verification
Take an acceptance edge k with `grant` already high. Then `hold` and `busy` appear after edge k and the acknowledge after edge k+1. The address phase follows edge k+2, and the data phase covers the clocks after edges k+3 to k+2+DATA_CYCLES. `done` and the read word follow edge k+3+DATA_CYCLES, and each clock of waiting for the grant shifts every later step by one. The bench reference model advances on the same rising edges as the design. All outputs are compared against that model at the following falling edge, so every expected value is read in the exact clock it becomes due. The word driven on `ead_in` changes every clock, so a capture taken on the wrong data-phase clock returns a different value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_DW    = 32;
    localparam int XB_AW    = 18;
    localparam int XB_LANES = XB_DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ACK  = 3'd2,
        ST_ADDR = 3'd3,
        ST_DATA = 3'd4,
        ST_END  = 3'd5
    } xb_state_e;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_LEVEL = 1'b1
    } xb_mode_e;

    typedef struct packed {
        logic [XB_AW-1:0]    addr;
        logic [XB_LANES-1:0] be_n;
        logic                write;
        logic [XB_DW-1:0]    wdata;
        xb_mode_e            mode;
    } xb_req_t;

    // Address word: word address in the low bits, upper bits forced to zero.
    function automatic logic [XB_DW-1:0] addr_word(input logic [XB_AW-1:0] a);
        return {{(XB_DW-XB_AW){1'b0}}, a};
    endfunction

    // Returns {wr_n, rd_n} for the given style, direction and clock class.
    function automatic logic [1:0] strobe_pair(input xb_mode_e m, input logic write,
                                               input logic framed, input logic strobe);
        logic [1:0] r;
        if (m == MODE_LEVEL) begin
            r[1] = framed ? ~write : 1'b1;
            r[0] = ~strobe;
        end else begin
            r[1] = ~(strobe & write);
            r[0] = ~(strobe & ~write);
        end
        return r;
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DATA_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      grant,
    output xb_state_e state,
    output logic      accept,
    output logic      last_beat
);
    localparam int CW = (DATA_CYCLES > 1) ? $clog2(DATA_CYCLES) : 1;

    xb_state_e      st_q, st_d;
    logic [CW-1:0]  beat_q;

    assign state     = st_q;
    assign accept    = (st_q == ST_IDLE) && req_valid;
    assign last_beat = (beat_q == CW'(DATA_CYCLES - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_REQ;
            ST_REQ:  if (grant)     st_d = ST_ACK;
            ST_ACK:                 st_d = ST_ADDR;
            ST_ADDR:                st_d = ST_DATA;
            ST_DATA: if (last_beat) st_d = ST_END;
            ST_END:                 st_d = ST_IDLE;
            default:                st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_DATA) beat_q <= beat_q + CW'(1);
            else                 beat_q <= '0;
        end
    end

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA) |-> (int'(beat_q) < DATA_CYCLES)); // R10

    AST_GRANT_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REQ && !grant) |=> (st_q == ST_REQ)); // R2

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
(
    input  xb_state_e            state,
    input  xb_req_t              req_q,
    output logic                 hold,
    output logic                 bgack_n,
    output logic                 ctl_oe,
    output logic                 ale_n,
    output logic                 wr_n,
    output logic                 rd_n,
    output logic [XB_LANES-1:0]  be_n,
    output logic                 ead_oe,
    output logic [XB_DW-1:0]     ead_out
);
    logic owned, framed, strobe;
    logic [1:0] sp;

    always_comb begin
        owned  = (state == ST_ACK) || (state == ST_ADDR) ||
                 (state == ST_DATA) || (state == ST_END);
        framed = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_END);
        strobe = (state == ST_DATA);
        sp     = strobe_pair(req_q.mode, req_q.write, framed, strobe);

        hold    = (state != ST_IDLE);
        bgack_n = ~owned;
        ctl_oe  = owned;
        ale_n   = ~framed;
        wr_n    = sp[1];
        rd_n    = sp[0];
        be_n    = strobe ? req_q.be_n : {XB_LANES{1'b1}};
        ead_oe  = (state == ST_ADDR) || (strobe && req_q.write);
        if (state == ST_ADDR) ead_out = addr_word(req_q.addr);
        else                  ead_out = req_q.wdata;
    end

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [XB_DW-1:0] ead_in,
    output logic [XB_DW-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (cap_en) rd_data <= ead_in;
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(rd_data)); // R10

endmodule

// File: rtl/xbus_master.sv
module xbus_master
    import xbus_pkg::*;
#(
    parameter int DATA_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_mode,
    input  logic                req_valid,
    input  logic [XB_AW-1:0]    req_addr,
    input  logic [XB_LANES-1:0] req_be_n,
    input  logic                req_write,
    input  logic [XB_DW-1:0]    req_wdata,
    output logic                busy,
    output logic                done,
    output logic [XB_DW-1:0]    rd_data,
    output logic                hold,
    input  logic                grant,
    output logic                bgack_n,
    output logic                bus_clk,
    output logic                ctl_oe,
    output logic                ale_n,
    output logic                wr_n,
    output logic                rd_n,
    output logic [XB_LANES-1:0] be_n,
    output logic                ead_oe,
    output logic [XB_DW-1:0]    ead_out,
    input  logic [XB_DW-1:0]    ead_in
);
    xb_state_e state;
    logic      accept, last_beat;
    xb_req_t   req_q;

    assign bus_clk = ~clk;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_END);

    xbus_seq #(.DATA_CYCLES(DATA_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .grant     (grant),
        .state     (state),
        .accept    (accept),
        .last_beat (last_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{addr: '0, be_n: '1, write: 1'b0, wdata: '0, mode: MODE_SPLIT};
        end else if (accept) begin
            req_q <= '{addr: req_addr, be_n: req_be_n, write: req_write,
                       wdata: req_wdata, mode: xb_mode_e'(strobe_mode)};
        end
    end

    xbus_drive u_drive (
        .state   (state),
        .req_q   (req_q),
        .hold    (hold),
        .bgack_n (bgack_n),
        .ctl_oe  (ctl_oe),
        .ale_n   (ale_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .be_n    (be_n),
        .ead_oe  (ead_oe),
        .ead_out (ead_out)
    );

    xbus_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_en  ((state == ST_DATA) && last_beat && !req_q.write),
        .ead_in  (ead_in),
        .rd_data (rd_data)
    );

    AST_NO_DRIVE_UNGRANTED: assert property (@(posedge clk) disable iff (rst)
        ctl_oe |-> (!bgack_n && hold)); // R2

    AST_ACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bgack_n |-> hold); // R2

    AST_ALE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!ale_n && !done) |=> !ale_n); // R4

    AST_LANES_ONLY_STROBED: assert property (@(posedge clk) disable iff (rst)
        (be_n != {XB_LANES{1'b1}}) |-> (!rd_n || !wr_n)); // R5

    AST_SPLIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (req_q.mode == MODE_SPLIT) |-> (wr_n || rd_n)); // R7

    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (req_q.mode == MODE_SPLIT && !rd_n) |-> !ead_oe); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R11

    AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(req_q)); // R13

endmodule

// File: tb/tb_xbus_master.sv
module tb_xbus_master;
    import xbus_pkg::*;

    localparam int N = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        strobe_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0, grant = 1'b1;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_be_n = 4'hF;
    logic [31:0] req_wdata = '0, ead_in = '0;
    logic        busy, done, hold, bgack_n, bus_clk, ctl_oe, ale_n, wr_n, rd_n, ead_oe;
    logic [31:0] rd_data, ead_out;
    logic [3:0]  be_n;

    xbus_master #(.DATA_CYCLES(N)) dut (
        .clk(clk), .rst(rst), .strobe_mode(strobe_mode), .req_valid(req_valid),
        .req_addr(req_addr), .req_be_n(req_be_n), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .hold(hold), .grant(grant), .bgack_n(bgack_n), .bus_clk(bus_clk),
        .ctl_oe(ctl_oe), .ale_n(ale_n), .wr_n(wr_n), .rd_n(rd_n), .be_n(be_n),
        .ead_oe(ead_oe), .ead_out(ead_out), .ead_in(ead_in)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    // Behavioural reference: phase 0 idle, 1 waiting, 2 acknowledge,
    // 3 address, 4 data, 5 closing.
    int          m_ph = 0, m_cnt = 0;
    logic [17:0] m_addr = '0;
    logic [3:0]  m_be = 4'hF;
    logic        m_w = 1'b0, m_lvl = 1'b0;
    logic [31:0] m_wd = '0, m_rd = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_cnt <= 0; m_rd <= '0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                       m_ph <= 1; m_addr <= req_addr; m_be <= req_be_n;
                       m_w <= req_write; m_wd <= req_wdata; m_lvl <= strobe_mode;
                   end
                1: if (grant) m_ph <= 2;
                2: m_ph <= 3;
                3: begin m_ph <= 4; m_cnt <= 0; end
                4: if (m_cnt == N-1) begin
                       m_ph <= 5;
                       if (!m_w) m_rd <= ead_in;
                   end else m_cnt <= m_cnt + 1;
                default: m_ph <= 0;
            endcase
        end
    end

    task automatic chk(input string tag, input string nm, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic compare();
        string wtag, rtag;
        logic  exp_wr, exp_rd;
        wtag = m_lvl ? "R9" : (m_w ? "R7" : "R8");
        rtag = wtag;
        exp_wr = m_lvl ? ((m_ph >= 3) ? !m_w : 1'b1) : !(m_ph == 4 && m_w);
        exp_rd = m_lvl ? !(m_ph == 4) : !(m_ph == 4 && !m_w);
        chk("R11", "busy", 32'(busy), 32'(m_ph != 0));
        chk("R2", "hold", 32'(hold), 32'(m_ph != 0));
        chk("R2", "bgack_n", 32'(bgack_n), 32'(!(m_ph >= 2)));
        chk("R2", "ctl_oe", 32'(ctl_oe), 32'(m_ph >= 2));
        chk("R4", "ale_n", 32'(ale_n), 32'(!(m_ph >= 3)));
        chk("R5", "be_n", 32'(be_n), 32'((m_ph == 4) ? m_be : 4'hF));
        chk("R6", "ead_oe", 32'(ead_oe), 32'(m_ph == 3 || (m_ph == 4 && m_w)));
        if (m_ph == 3) chk("R3", "ead addr", ead_out, {14'b0, m_addr});
        if (m_ph == 4 && m_w) chk("R6", "ead wdata", ead_out, m_wd);
        chk(wtag, "wr_n", 32'(wr_n), 32'(exp_wr));
        chk(rtag, "rd_n", 32'(rd_n), 32'(exp_rd));
        chk("R10", "done", 32'(done), 32'(m_ph == 5));
        if (m_ph == 5 && !m_w) chk("R10", "rd_data", rd_data, m_rd);
        chk("R12", "bus_clk low-phase", 32'(bus_clk), 32'd1);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        cyc++;
        ead_in = 32'hA500_0000 + 32'(cyc);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic issue(input logic [17:0] a, input logic [3:0] be, input logic w,
                         input logic [31:0] d, input logic lvl);
        req_valid = 1'b1; req_addr = a; req_be_n = be; req_write = w;
        req_wdata = d; strobe_mode = lvl;
        step();
        req_valid = 1'b0;
    endtask

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "hold", 32'(hold), 0);
        chk("R1", "bgack_n", 32'(bgack_n), 1);
        chk("R1", "ctl_oe/ead_oe", {30'b0, ctl_oe, ead_oe}, 0);
        chk("R1", "ale_n/wr_n/rd_n", {29'b0, ale_n, wr_n, rd_n}, 32'h7);
        chk("R1", "be_n", 32'(be_n), 32'hF);
        chk("R1", "done", 32'(done), 0);
        rst = 1'b0;
        run(2);

        issue(18'h2_A5C3, 4'b1010, 1'b1, 32'hDEAD_BEEF, 1'b0);  // R7 split write
        run(9);
        issue(18'h0_0041, 4'b0000, 1'b0, 32'h0, 1'b0);          // R8 split read
        run(9);
        issue(18'h3_FFFF, 4'b0111, 1'b1, 32'h1234_5678, 1'b1);  // R9 level write
        run(9);
        issue(18'h1_0F0F, 4'b1100, 1'b0, 32'h0, 1'b1);          // R9 level read
        run(9);

        // R2: delayed grant, nothing driven while waiting
        grant = 1'b0;
        issue(18'h0_1234, 4'b1110, 1'b1, 32'hCAFE_F00D, 1'b0);
        run(5);
        grant = 1'b1;
        run(9);

        // R11 and R13: request held with different fields and style while busy
        issue(18'h2_2222, 4'b0101, 1'b1, 32'h5A5A_A5A5, 1'b0);
        req_valid = 1'b1; req_addr = 18'h3_3333; req_be_n = 4'b0011;
        req_write = 1'b0; strobe_mode = 1'b1;
        run(3);
        strobe_mode = 1'b0;
        run(3);
        req_valid = 1'b0;
        run(12);

        // R12: high clock phase
        @(posedge clk); #1;
        chk("R12", "bus_clk high-phase", 32'(bus_clk), 32'd0);
        run(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule